// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master

This block is a serial master port on a small register interface. Software sets two control words, pushes words to send through a data address, pops received words from the same address, and polls a status word. The port moves each word as one frame of 4 to 16 bits. Three framing styles are available. The first uses a frame select held low for the whole frame. The second sends a one-period high pulse on the frame line ahead of the data. The third sends an 8-bit command and then listens for a reply of the programmed length.

The serial clock comes from a programmable even divider of the system clock, or from an external clock input that is synchronised and stepped on each of its transitions. Polarity and phase are programmable. Eight-word transmit and receive queues raise level-based service requests. A receive queue that is full when a frame completes raises a sticky overrun flag. A loopback mode feeds the transmitted line straight into the receiver.

Top module: `sync_serial_port`

## Requirements
- R1: Register map: address 0 holds control word A (bits 3:0 size code, bits 5:4 format, bit 7 enable, bits 15:8 divider value D); address 1 holds control word B (bit 0 receive interrupt enable, bit 1 transmit interrupt enable, bit 2 loopback, bit 3 clock idle level, bit 4 phase, bit 5 external clock); address 2 is data; address 3 is status (bit 0 transmit not full, bit 1 receive not empty, bit 2 busy, bit 3 transmit request, bit 4 receive request, bit 5 overrun). After reset status reads 0x0009, the frame line is high, and the clock and data lines are low.
- R2: The data length N is the size code plus one; codes 0, 1 and 2 give N = 4.
- R3: Format 0 (and 3) and format 2 hold the frame line low for exactly the frame and high otherwise. Format 1 keeps it low when idle and drives it high for one serial period just before the first data bit.
- R4: Bits go out most significant first. Each bit starts with a half period at the idle level and then a half period at the active level. The receiver samples at the idle-to-active edge. In format 2, bits 7..0 of the word are sent, and then N bits are received while the transmit line is low. In formats 0, 1 and 3, N bits are exchanged.
- R5: With the internal clock, each half period lasts D+1 system clocks, so the serial period is 2(D+1).
- R6: The serial clock rests at the level given by the idle-level bit.
- R7: In formats 0, 2 and 3, the first active clock level comes one half period after the frame line falls when phase is 0, and one full period after it falls when phase is 1.
- R8: With the external clock selected, every transition of the external clock advances the frame by one half period. With no transitions, the frame holds.
- R9: In loopback the receiver takes the transmit line and ignores the receive pin.
- R10: Each queue holds 8 words. A data write pushes only when the port is enabled and the queue is not full; otherwise it is dropped. A data read pops the oldest received word, and a read of an empty queue returns 0.
- R11: The transmit request is 1 while 4 or fewer words wait to be sent. The receive request is 1 while 4 or more words are held. The transmit interrupt is the transmit request ANDed with its enable and the port enable. The receive interrupt is the receive request ANDed with its enable.
- R12: A frame that completes while the receive queue is full is discarded and sets overrun. Overrun stays set until a status write with bit 5 at 1 clears it.
- R13: While the enable bit is 0, both queues are empty, any frame is stopped, and data writes are dropped.
- R14: Busy is 1 while a frame is in progress or the transmit queue holds a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops on data) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| tx_irq | output | 1 | Transmit service interrupt |
| rx_irq | output | 1 | Receive service interrupt |
| sclk | output | 1 | Serial clock |
| sfrm | output | 1 | Frame line |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| ext_clk | input | 1 | External serial clock source |

## Verification
A corrupt half-step counter shows up within the same frame, as an edge count or a frame-line width that differs from the format's formula. A queue pointer or count that slips shows up at the next data read as a word out of order, a stale word, or a status bit that does not match the number of words written. An overrun flag set or cleared at the wrong time is visible in the status word as soon as the ninth frame ends.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DEPTH = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          tx_irq,
  output logic          rx_irq,
  output logic          sclk,
  output logic          sfrm,
  output logic          txd,
  input  logic          rxd,
  input  logic          ext_clk
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] HALFV = CW'(DEPTH / 2);

  logic [15:0] c0;
  logic [5:0]  c1;
  logic [DW-1:0] txm [DEPTH];
  logic [DW-1:0] rxm [DEPTH];
  logic [PW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;
  logic          act, ovr;
  logic [5:0]    step;
  logic [7:0]    div;
  logic [15:0]   tw, rsh;
  logic [2:0]    es;

  logic en, is_ti, is_mw, rie, tie, loop_en, pol, pha, ext_sel;
  logic [1:0] fmt;
  logic [7:0] scr;
  assign en      = c0[7];
  assign fmt     = c0[5:4];
  assign scr     = c0[15:8];
  assign is_ti   = fmt == 2'd1;
  assign is_mw   = fmt == 2'd2;
  assign rie     = c1[0];
  assign tie     = c1[1];
  assign loop_en = c1[2];
  assign pol     = c1[3];
  assign pha     = c1[4];
  assign ext_sel = c1[5];

  logic [4:0] nbits, tbits, bitn;
  logic [5:0] lead, total, pos;
  assign nbits = (c0[3:0] < 4'd3) ? 5'd4 : {1'b0, c0[3:0]} + 5'd1;
  assign tbits = is_mw ? nbits + 5'd8 : nbits;
  assign lead  = is_ti ? 6'd2 : {5'd0, pha};
  assign total = lead + {tbits, 1'b0};
  assign pos   = step - lead;
  assign bitn  = pos[5:1];

  logic tick, start, in_bits, half, finish, sample;
  logic wr_data, rd_data, wr_stat, tpush, rpush, rpop;
  assign tick    = ext_sel ? (es[2] ^ es[1]) : (div == scr);
  assign start   = en && !act && tcnt != '0;
  assign in_bits = step >= lead;
  assign half    = pos[0];
  assign finish  = en && act && tick && step == total - 6'd1;
  assign sample  = act && tick && in_bits && !half && (!is_mw || bitn >= 5'd8);
  assign wr_data = wr_en && addr == 2'd2;
  assign rd_data = rd_en && addr == 2'd2;
  assign wr_stat = wr_en && addr == 2'd3;
  assign tpush   = wr_data && en && tcnt != FULL;
  assign rpush   = finish && rcnt != FULL;
  assign rpop    = rd_data && rcnt != '0;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic tbit;
  always_comb begin
    tbit = 1'b0;
    if (act && in_bits) begin
      if (is_mw) tbit = (bitn < 5'd8) ? tw[{1'b0, 3'd7 - bitn[2:0]}] : 1'b0;
      else       tbit = tw[4'(nbits - 5'd1 - bitn)];
    end
  end

  assign txd  = tbit;
  assign sclk = pol ^ (act && in_bits && half);
  assign sfrm = is_ti ? (act && !in_bits) : !act;

  logic busy, tx_req, rx_req;
  assign busy   = act || tcnt != '0;
  assign tx_req = tcnt <= HALFV;
  assign rx_req = rcnt >= HALFV;
  assign tx_irq = en && tie && tx_req;
  assign rx_irq = rie && rx_req;

  always_comb begin
    case (addr)
      2'd0:    rdata = c0;
      2'd1:    rdata = {10'd0, c1};
      2'd2:    rdata = (rcnt != '0) ? rxm[rrp] : '0;
      default: rdata = {10'd0, ovr, rx_req, tx_req, busy, rcnt != '0, tcnt != FULL};
    endcase
  end

  always_ff @(posedge clk) begin
    if (tpush) txm[twp] <= wdata;
    if (rpush) rxm[rwp] <= rsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0 <= '0; c1 <= '0; es <= '0;
      twp <= '0; trp <= '0; rwp <= '0; rrp <= '0;
      tcnt <= '0; rcnt <= '0;
      act <= 1'b0; ovr <= 1'b0; step <= '0; div <= '0; tw <= '0; rsh <= '0;
    end else begin
      es <= {es[1:0], ext_clk};
      if (wr_en && addr == 2'd0) c0 <= wdata;
      if (wr_en && addr == 2'd1) c1 <= wdata[5:0];
      if (finish && rcnt == FULL)  ovr <= 1'b1;
      else if (wr_stat && wdata[5]) ovr <= 1'b0;
      if (!en) begin
        act <= 1'b0;
        twp <= '0; trp <= '0; rwp <= '0; rrp <= '0;
        tcnt <= '0; rcnt <= '0;
      end else begin
        if (tpush) twp <= inc(twp);
        if (start) trp <= inc(trp);
        tcnt <= tcnt + CW'(tpush) - CW'(start);
        if (rpush) rwp <= inc(rwp);
        if (rpop)  rrp <= inc(rrp);
        rcnt <= rcnt + CW'(rpush) - CW'(rpop);
        if (start) begin
          act <= 1'b1; step <= '0; div <= '0; tw <= txm[trp]; rsh <= '0;
        end else if (act) begin
          div <= (div == scr) ? '0 : div + 8'd1;
          if (tick) begin
            if (finish) act <= 1'b0;
            else        step <= step + 6'd1;
          end
          if (sample) rsh <= {rsh[14:0], loop_en ? tbit : rxd};
        end
      end
    end
  end

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= FULL && rcnt <= FULL);
  p_tx_step_r10: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $past(en) |-> (tcnt == $past(tcnt) || tcnt == $past(tcnt) + CW'(1) || tcnt + CW'(1) == $past(tcnt)));
  p_ovr_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rcnt) == FULL);
  p_ovr_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !(wr_stat && wdata[5]) |=> ovr);
  p_flush_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tcnt == '0 && rcnt == '0 && !act));
  p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) && $past(en) |-> $past(step) == $past(total) - 6'd1);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act && !tick |=> step == $past(step));
endmodule

// File: tb/test_sync_serial_port.sv
`timescale 1ns/1ps
module test_sync_serial_port;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] wdata = 0, rdata;
  logic tx_irq, rx_irq, sclk, sfrm, txd, rxd;
  logic ext_clk = 0;
  bit   ext_run = 0;

  int nchk = 0, nerr = 0;
  int clr_req = 0, clr_seen = 0;
  int cur_t = 4;
  logic cur_pol = 0;
  logic [23:0] sw = 0;
  int ecnt, lo, hi, ld;
  logic [23:0] cap;
  logic prev;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .sclk(sclk), .sfrm(sfrm), .txd(txd), .rxd(rxd), .ext_clk(ext_clk));

  always #10 clk = ~clk;
  always begin #35; if (ext_run) ext_clk = ~ext_clk; end

  always @(negedge clk) begin
    if (clr_seen != clr_req) begin
      clr_seen = clr_req; ecnt = 0; cap = 0; lo = 0; hi = 0; ld = 0; prev = sclk;
    end else begin
      if (sclk != cur_pol && prev == cur_pol) begin cap = {cap[22:0], txd}; ecnt++; end
      prev = sclk;
      if (!sfrm) lo++; else hi++;
      if (!sfrm && ecnt == 0) ld++;
    end
    rxd = (ecnt < cur_t) ? sw[cur_t-1-ecnt] : 1'b0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
    $finish;
  end

  task automatic chk(input string tag, input int unsigned a, input int unsigned e);
    nchk++;
    if (a != e) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int k = 0; k < 20000; k++) begin
      rd(2'd3, s);
      if (!s[2]) break;
    end
  endtask

  function automatic int nb_of(input int dss);
    return (dss < 3) ? 4 : dss + 1;
  endfunction

  function automatic logic [23:0] exp_stream(input int fmt, input int dss, input logic [15:0] d);
    int n = nb_of(dss);
    if (fmt == 2) return 24'(d[7:0]) << n;
    return 24'(d) & ((24'd1 << n) - 24'd1);
  endfunction

  function automatic logic [15:0] exp_rx(input int fmt, input int dss, input bit lp,
                                         input logic [15:0] d, input logic [23:0] s);
    logic [23:0] m = (24'd1 << nb_of(dss)) - 24'd1;
    if (lp) return (fmt == 2) ? 16'd0 : 16'(24'(d) & m);
    return 16'(s & m);
  endfunction

  task automatic xfer(input int fmt, input int dss, input int scr, input bit pol,
                      input bit pha, input bit lp, input logic [15:0] d, input logic [23:0] s);
    logic [15:0] got;
    int t = (fmt == 2) ? nb_of(dss) + 8 : nb_of(dss);
    cur_pol = pol; cur_t = t; sw = s;
    wr(2'd1, {10'd0, 1'b0, pha, pol, lp, 2'b00});
    wr(2'd0, {8'(scr), 1'b1, 1'b0, 2'(fmt), 4'(dss)});
    clr_req++;
    @(negedge clk); @(negedge clk);
    wr(2'd2, d);
    wait_idle();
    rd(2'd2, got);
    chk("R2 active edge count", ecnt, t);
    chk("R4 transmitted bit stream", cap, exp_stream(fmt, dss, d));
    chk(lp ? "R9 loopback word" : "R4 received word", got, exp_rx(fmt, dss, lp, d, s));
    chk("R6 idle clock level", sclk, pol);
    if (fmt == 1) chk("R3 framed pulse width", hi, 2 * (scr + 1));
    else begin
      chk("R5 frame length in clocks", lo, (pha + 2 * t) * (scr + 1));
      chk("R7 lead before first active edge", ld, (pha + 1) * (scr + 1));
    end
  endtask

  initial begin
    logic [15:0] s, v;
    int unsigned seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd3, s);
    chk("R1 reset status", s, 16'h0009);
    chk("R1 reset frame line", sfrm, 1);
    chk("R1 reset clock", sclk, 0);
    chk("R1 reset data", txd, 0);
    chk("R11 reset irqs", {tx_irq, rx_irq}, 0);

    xfer(0, 7, 0, 0, 0, 0, 16'h00A5, 24'h00003C);
    xfer(0, 15, 2, 1, 1, 0, 16'hBEEF, 24'h00C3A1);
    xfer(1, 11, 1, 0, 0, 0, 16'h0ABC, 24'h000591);
    xfer(2, 3, 0, 0, 0, 0, 16'h00D2, 24'h000E09);
    xfer(0, 1, 1, 0, 1, 1, 16'hFFF6, 24'h000000);
    xfer(2, 9, 0, 1, 0, 1, 16'h1281, 24'h0FFFFF);

    for (int i = 0; i < 40; i++) begin
      int f = $urandom_range(2, 0);
      xfer(f, $urandom_range(15, 0), $urandom_range(3, 0), 1'($urandom), 1'($urandom),
           1'($urandom), 16'($urandom), 24'($urandom));
    end

    wr(2'd1, 16'h0027);
    wr(2'd0, 16'h008F);
    cur_pol = 0;
    wr(2'd2, 16'hA000);
    for (int k = 1; k <= 8; k++) begin
      wr(2'd2, 16'hA000 + 16'(k));
      if (k == 4) begin
        rd(2'd3, s);
        chk("R11 transmit request at 4 waiting", s[3], 1);
        chk("R11 transmit irq at 4 waiting", tx_irq, 1);
      end
      if (k == 5) begin
        rd(2'd3, s);
        chk("R11 transmit request at 5 waiting", s[3], 0);
        chk("R11 transmit irq at 5 waiting", tx_irq, 0);
      end
    end
    wr(2'd2, 16'hA009);
    repeat (20) @(negedge clk);
    rd(2'd3, s);
    chk("R10 full queue status", s[3:0], 4'h4);
    chk("R14 busy while stalled", s[2], 1);
    chk("R8 clock holds without edges", sclk, 0);
    ext_run = 1;
    wait_idle();
    ext_run = 0;
    rd(2'd3, s);
    chk("R12 overrun status after nine frames", s[5:0], 6'h3B);
    chk("R11 receive irq", rx_irq, 1);
    for (int k = 0; k < 4; k++) begin
      rd(2'd2, v);
      chk("R10 receive order", v, 16'hA000 + 16'(k));
    end
    rd(2'd3, s);
    chk("R11 receive request at 4 held", s[4], 1);
    rd(2'd2, v);
    chk("R10 receive order", v, 16'hA004);
    rd(2'd3, s);
    chk("R11 receive request at 3 held", s[4], 0);
    for (int k = 5; k < 8; k++) begin
      rd(2'd2, v);
      chk("R10 receive order", v, 16'hA000 + 16'(k));
    end
    rd(2'd2, v);
    chk("R12 discarded frame, empty read returns 0", v, 0);
    rd(2'd3, s);
    chk("R12 overrun held until cleared", s[5:0], 6'h29);
    wr(2'd3, 16'h0020);
    rd(2'd3, s);
    chk("R12 overrun cleared", s[5], 0);

    wr(2'd2, 16'h1111);
    wr(2'd2, 16'h2222);
    wr(2'd2, 16'h3333);
    rd(2'd3, s);
    chk("R14 busy with words queued", s[2], 1);
    wr(2'd0, 16'h000F);
    rd(2'd3, s);
    chk("R13 disable flushes", s[4:0], 5'h09);
    chk("R13 disabled frame line", sfrm, 1);
    wr(2'd2, 16'h4444);
    wr(2'd0, 16'h008F);
    rd(2'd3, s);
    chk("R13 write while disabled dropped", s[4:0], 5'h09);
    chk("R13 no frame after enable", sfrm, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule